// File: doc/BRIEF.md
# Latched Interrupt Controller

This block turns short event pulses from status sources (for example lock gained, lock lost, caption data ready, standard changed) into sticky status bits that a host reads through a simple parallel register port. Besides pulse events, the block watches a set of raw level inputs (such as vertical and horizontal lock). It keeps those levels readable as they are and latches a separate change bit whenever one of them toggles. A software-writable trigger adds one more event source with its own status, clear and enable bits.

The host enables sources through an enable register (1 = enabled), acknowledges them by writing ones to a clear register, and chooses how the single interrupt pin is driven and how long it stays active. An interrupt is raised only when the set of enabled, latched bits goes from empty to non-empty. Later events that arrive while earlier enabled bits are still latched raise no new interrupt.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, the config register (address 0), status register (address 1) and enable register (address 3) all read 0, and `irq_oe_o` is low, so the pin floats until a drive mode is written.
- R2: An event pulse on `evt_i[k]` sets status bit k (bits 3:0) one clock later. It does so whether or not the source is enabled, and a disabled source raises no interrupt.
- R3: Writing address 2 clears every status bit whose written data bit is 1 and leaves the others unchanged. Address 2 always reads 0.
- R4: When an event arrives in the same cycle as a clear of the same bit, the bit stays set.
- R5: Address 4 returns the current `lvl_i` levels in bits 1:0. Any toggle of `lvl_i[j]` in either direction sets latched change bit 4+j in the status register.
- R6: A new interrupt starts only when the enabled-and-latched set changes from empty to non-empty. An event on another source, or clearing one of two latched bits, raises none while any enabled bit stays latched.
- R7: Duration field config[3:2] = 00, 01 or 10 gives an active pulse of 3, 15 or 63 clocks. The pulse starts two clocks after the event pulse.
- R8: With duration 11 (level mode), the interrupt stays active as long as any enabled status bit is set. It drops one clock after the clear that empties that set.
- R9: Drive field config[1:0] selects the pin drive: 00 floats; 01 drives 0 only while active and floats otherwise; 10 drives active low; 11 drives active high.
- R10: Writing config with bit 4 = 1 sets software status bit 6, which follows the same enable and clear rules as the other bits. Config bit 4 always reads 0.
- R11: Enabling a source whose status bit is already latched, while no other enabled bit is set, starts an interrupt one clock after the enable-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_SRC | Single-cycle event pulses |
| lvl_i | input | NUM_LVL | Raw level status inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational) |
| irq_o | output | 1 | Interrupt pin value |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
Two functions can land in the same clock edge: a hardware event setting a bit, and a host write clearing that same bit. The bench provokes this by driving an event pulse and a clear-register write in one cycle, with one other latched bit included in the clear mask. It then expects the colliding bit to survive while the other bit is cleared. A second overlap, a fresh event arriving while an older enabled bit is still latched, is judged cycle by cycle on the pin through the scoreboard queue, which must show no new pulse.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic [1:0] {
      DRV_TRI     = 2'b00,
      DRV_OD_LOW  = 2'b01,
      DRV_PP_LOW  = 2'b10,
      DRV_PP_HIGH = 2'b11
   } drv_mode_e;

   typedef enum logic [1:0] {
      DUR_SHORT = 2'b00,
      DUR_MID   = 2'b01,
      DUR_LONG  = 2'b10,
      DUR_LEVEL = 2'b11
   } dur_sel_e;

   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
   localparam logic [ADDR_W-1:0] A_CLR  = 3'd2;
   localparam logic [ADDR_W-1:0] A_EN   = 3'd3;
   localparam logic [ADDR_W-1:0] A_RAW  = 3'd4;

   localparam int unsigned CFG_SOFT_BIT = 4;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned NUM_LVL = 2,
   localparam int unsigned NB     = NUM_SRC + NUM_LVL + 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_LVL-1:0] lvl_i,
   input  logic               soft_i,
   input  logic [NB-1:0]      clr_i,
   input  logic               en_wr_i,
   input  logic [NB-1:0]      en_d_i,
   output logic [NB-1:0]      stat_o,
   output logic [NB-1:0]      en_o,
   output logic               pend_o
);

   if (NUM_SRC < 1 || NUM_LVL < 1) begin : g_bad_cfg
      $error("irq_status_bank: NUM_SRC and NUM_LVL must be at least 1");
   end

   logic [NUM_LVL-1:0] lvl_q;
   logic [NUM_LVL-1:0] chg;
   logic               vld_q;
   logic [NB-1:0]      stat_q;
   logic [NB-1:0]      en_q;
   logic [NB-1:0]      set_vec;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) vld_q <= 1'b0;
      else         vld_q <= 1'b1;
   end

   for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      always_ff @(posedge clk_i) begin
         if (!rst_ni) lvl_q[l] <= 1'b0;
         else         lvl_q[l] <= lvl_i[l];
      end
      assign chg[l] = vld_q & (lvl_i[l] ^ lvl_q[l]);
   end

   assign set_vec = {soft_i, chg, evt_i};

   for (genvar b = 0; b < NB; b++) begin : g_bit
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            stat_q[b] <= 1'b0;
            en_q[b]   <= 1'b0;
         end else begin
            stat_q[b] <= (stat_q[b] & ~clr_i[b]) | set_vec[b];
            if (en_wr_i) en_q[b] <= en_d_i[b];
         end
      end
   end

   assign stat_o = stat_q;
   assign en_o   = en_q;
   assign pend_o = |(stat_q & en_q);

   AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec))); // R2
   AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(set_vec & clr_i)) |=> ((stat_q & $past(set_vec & clr_i)) == $past(set_vec & clr_i))); // R4
   AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(clr_i & ~set_vec)) |=> ((stat_q & $past(clr_i & ~set_vec)) == '0)); // R3

endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen
   import irq_pkg::*;
#(
   parameter int unsigned DUR0 = 3,
   parameter int unsigned DUR1 = 15,
   parameter int unsigned DUR2 = 63,
   localparam int unsigned CNT_W = $clog2(DUR2 + 1)
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     pend_i,
   input  dur_sel_e dur_i,
   output logic     act_o
);

   if (DUR0 < 1 || DUR1 <= DUR0 || DUR2 <= DUR1) begin : g_bad_dur
      $error("irq_pulse_gen: durations must be positive and increasing");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len;
   logic             pend_q;
   logic             lvl_act_q;
   logic             rise;
   logic             pulse_mode;

   assign rise       = pend_i & ~pend_q;
   assign pulse_mode = (dur_i != DUR_LEVEL);

   always_comb begin
      unique case (dur_i)
         DUR_SHORT: len = CNT_W'(DUR0);
         DUR_MID:   len = CNT_W'(DUR1);
         default:   len = CNT_W'(DUR2);
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pend_q    <= 1'b0;
         lvl_act_q <= 1'b0;
         cnt_q     <= '0;
      end else begin
         pend_q    <= pend_i;
         lvl_act_q <= pend_i;
         if (rise && pulse_mode)   cnt_q <= len;
         else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
      end
   end

   assign act_o = pulse_mode ? (cnt_q != '0) : lvl_act_q;

   // run-length monitor for the pulse bound check
   logic [CNT_W:0] hi_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni)                                 hi_q <= '0;
      else if (act_o && pulse_mode && (&hi_q) == 1'b0) hi_q <= hi_q + 1'b1;
      else if (!(act_o && pulse_mode))             hi_q <= '0;
   end

   AST_NO_RETRIGGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(pend_q) && pulse_mode && $past(pulse_mode)) |-> !$rose(act_o)); // R6
   AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hi_q <= (CNT_W+1)'(DUR2)); // R7

endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
   import irq_pkg::*;
(
   input  drv_mode_e mode_i,
   input  logic      act_i,
   output logic      pin_o,
   output logic      oe_o
);

   always_comb begin
      pin_o = 1'b0;
      oe_o  = 1'b0;
      unique case (mode_i)
         DRV_OD_LOW:  begin oe_o = act_i; pin_o = 1'b0;   end
         DRV_PP_LOW:  begin oe_o = 1'b1;  pin_o = ~act_i; end
         DRV_PP_HIGH: begin oe_o = 1'b1;  pin_o = act_i;  end
         default:     begin oe_o = 1'b0;  pin_o = 1'b0;   end
      endcase
   end

   always_comb begin
      if (mode_i == DRV_TRI) AST_TRI_FLOATS: assert (!oe_o); // R9
   end

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned NUM_LVL = 2,
   parameter int unsigned DW      = 8,
   parameter int unsigned DUR0    = 3,
   parameter int unsigned DUR1    = 15,
   parameter int unsigned DUR2    = 63
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_LVL-1:0] lvl_i,
   input  logic               reg_wr_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DW-1:0]      reg_wdata_i,
   output logic [DW-1:0]      reg_rdata_o,
   output logic               irq_o,
   output logic               irq_oe_o
);

   localparam int unsigned NB = NUM_SRC + NUM_LVL + 1;

   if (DW < NB || DW <= CFG_SOFT_BIT) begin : g_bad_dw
      $error("irq_latch_ctrl: DW too narrow for the status vector or config");
   end

   drv_mode_e drv_q;
   dur_sel_e  dur_q;
   logic      cfg_wr, en_wr, soft_evt, act, pend;
   logic [NB-1:0] clr_vec, stat, en;

   assign cfg_wr   = reg_wr_i && (reg_addr_i == A_CFG);
   assign en_wr    = reg_wr_i && (reg_addr_i == A_EN);
   assign soft_evt = cfg_wr && reg_wdata_i[CFG_SOFT_BIT];
   assign clr_vec  = (reg_wr_i && (reg_addr_i == A_CLR)) ? reg_wdata_i[NB-1:0] : '0;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         drv_q <= DRV_TRI;
         dur_q <= DUR_SHORT;
      end else if (cfg_wr) begin
         drv_q <= drv_mode_e'(reg_wdata_i[1:0]);
         dur_q <= dur_sel_e'(reg_wdata_i[3:2]);
      end
   end

   if (DW > NB) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^reg_wdata_i[DW-1:NB];
   end

   irq_status_bank #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_i),
      .lvl_i   (lvl_i),
      .soft_i  (soft_evt),
      .clr_i   (clr_vec),
      .en_wr_i (en_wr),
      .en_d_i  (reg_wdata_i[NB-1:0]),
      .stat_o  (stat),
      .en_o    (en),
      .pend_o  (pend)
   );

   irq_pulse_gen #(.DUR0(DUR0), .DUR1(DUR1), .DUR2(DUR2)) u_pulse (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pend_i (pend),
      .dur_i  (dur_q),
      .act_o  (act)
   );

   irq_pin_drive u_drive (
      .mode_i (drv_q),
      .act_i  (act),
      .pin_o  (irq_o),
      .oe_o   (irq_oe_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_addr_i)
         A_CFG:   begin reg_rdata_o[1:0] = drv_q; reg_rdata_o[3:2] = dur_q; end
         A_STAT:  reg_rdata_o[NB-1:0] = stat;
         A_EN:    reg_rdata_o[NB-1:0] = en;
         A_RAW:   reg_rdata_o[NUM_LVL-1:0] = lvl_i;
         default: reg_rdata_o = '0;
      endcase
   end

endmodule

// File: tb/sim_irq_latch_ctrl.sv
`timescale 1ns/1ps
module sim_irq_latch_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] evt = '0;
   logic [1:0] lvl = '0;
   logic       wr = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq, irq_oe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [1:0] q_pin[$];
   string      q_req[$];

   always #10 clk = ~clk;

   irq_latch_ctrl u0 (
      .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .lvl_i(lvl),
      .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq), .irq_oe_o(irq_oe)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor: one expected {oe,pin} per cycle
   always @(negedge clk) begin
      if (q_pin.size() > 0) begin
         logic [1:0] e;
         string r;
         e = q_pin.pop_front();
         r = q_req.pop_front();
         n_tests++;
         if ({irq_oe, irq} !== e) begin
            n_fail++;
            $display("FAIL %s pin oe/o actual %b%b expected %b%b", r, irq_oe, irq, e[1], e[0]);
         end
      end
   end

   task automatic push(input logic oe, input logic o, input int n, input string req);
      for (int i = 0; i < n; i++) begin
         q_pin.push_back({oe, o});
         q_req.push_back(req);
      end
   endtask

   task automatic push_pulse(input int len, input string req);
      push(1'b1, 1'b0, 1, req);
      push(1'b1, 1'b1, len, req);
      push(1'b1, 1'b0, 1, req);
   endtask

   task automatic drain();
      while (q_pin.size() > 0) @(negedge clk);
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
      @(posedge clk); #2;
      wr = 1'b1; addr = a; wdata = d;
      @(posedge clk); #2;
      wr = 1'b0; wdata = '0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
      @(posedge clk); #2;
      addr = a;
      @(negedge clk);
      d = rdata;
   endtask

   task automatic pulse_evt(input logic [3:0] b);
      @(posedge clk); #2;
      evt = b;
      @(posedge clk); #2;
      evt = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int lens[3];
      lens[0] = 3; lens[1] = 15; lens[2] = 63;

      repeat (5) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset state
      reg_read(3'd0, d); check("R1", "cfg", d, 8'h00);
      reg_read(3'd1, d); check("R1", "status", d, 8'h00);
      reg_read(3'd3, d); check("R1", "enable", d, 8'h00);
      check("R1", "oe", irq_oe, 0);

      // R5 raw levels and change bits
      @(posedge clk); #2 lvl = 2'b10;
      reg_read(3'd4, d); check("R5", "raw", d, 8'h02);
      reg_read(3'd1, d); check("R5", "status after rise", d, 8'h20);
      reg_write(3'd2, 8'h20);
      @(posedge clk); #2 lvl = 2'b11;
      reg_read(3'd1, d); check("R5", "status low bit rise", d, 8'h10);
      reg_write(3'd2, 8'h10);
      @(posedge clk); #2 lvl = 2'b01;
      reg_read(3'd1, d); check("R5", "status after fall", d, 8'h20);
      reg_read(3'd4, d); check("R5", "raw", d, 8'h01);
      reg_write(3'd2, 8'h30);
      reg_read(3'd1, d); check("R3", "all cleared", d, 8'h00);
      reg_read(3'd2, d); check("R3", "clear reads zero", d, 8'h00);

      // R2 disabled source latches, no interrupt
      reg_write(3'd0, 8'h03);
      pulse_evt(4'b0100);
      reg_read(3'd1, d); check("R2", "status", d, 8'h04);
      check("R2", "pin idle oe", irq_oe, 1);
      check("R2", "pin idle level", irq, 0);

      // R11 enabling a latched source starts a pulse
      reg_write(3'd3, 8'h7F);
      push_pulse(3, "R11");
      drain();
      reg_write(3'd2, 8'h04);

      // R7 durations
      for (int k = 0; k < 3; k++) begin
         reg_write(3'd0, 8'(k * 4 + 3));
         pulse_evt(4'b0001);
         push_pulse(lens[k], "R7");
         drain();
         reg_write(3'd2, 8'h01);
      end

      // R6 no retrigger while pending
      reg_write(3'd0, 8'h03);
      pulse_evt(4'b0001);
      push_pulse(3, "R6");
      drain();
      pulse_evt(4'b0010);
      push(1'b1, 1'b0, 8, "R6");
      drain();
      reg_write(3'd2, 8'h01);
      push(1'b1, 1'b0, 6, "R6");
      drain();
      reg_read(3'd1, d); check("R6", "status", d, 8'h02);
      reg_write(3'd2, 8'h02);
      pulse_evt(4'b0100);
      push_pulse(3, "R6");
      drain();
      reg_write(3'd2, 8'h04);

      // R4 set and clear in one cycle
      pulse_evt(4'b0010);
      idle(6);
      @(posedge clk); #2;
      evt = 4'b0001; wr = 1'b1; addr = 3'd2; wdata = 8'h03;
      @(posedge clk); #2;
      evt = '0; wr = 1'b0; wdata = '0;
      reg_read(3'd1, d); check("R4", "set wins", d, 8'h01);
      reg_write(3'd2, 8'h01);
      idle(2);

      // R8 level mode
      reg_write(3'd0, 8'h0F);
      pulse_evt(4'b1000);
      push(1'b1, 1'b0, 1, "R8");
      push(1'b1, 1'b1, 10, "R8");
      drain();
      pulse_evt(4'b0001);
      reg_write(3'd2, 8'h08);
      push(1'b1, 1'b1, 3, "R8");
      drain();
      reg_write(3'd2, 8'h01);
      push(1'b1, 1'b1, 1, "R8");
      push(1'b1, 1'b0, 2, "R8");
      drain();

      // R9 drive modes, active then inactive
      pulse_evt(4'b0001);
      idle(2);
      reg_write(3'd0, 8'h0C); @(negedge clk); check("R9", "tri active oe", irq_oe, 0);
      reg_write(3'd0, 8'h0D); @(negedge clk); check("R9", "od active oe", irq_oe, 1);
      check("R9", "od active pin", irq, 0);
      reg_write(3'd0, 8'h0E); @(negedge clk); check("R9", "low active pin", {irq_oe, irq}, 2'b10);
      reg_write(3'd0, 8'h0F); @(negedge clk); check("R9", "high active pin", {irq_oe, irq}, 2'b11);
      reg_write(3'd2, 8'h01);
      idle(2);
      reg_write(3'd0, 8'h0C); @(negedge clk); check("R9", "tri idle oe", irq_oe, 0);
      reg_write(3'd0, 8'h0D); @(negedge clk); check("R9", "od idle oe", irq_oe, 0);
      reg_write(3'd0, 8'h0E); @(negedge clk); check("R9", "low idle pin", {irq_oe, irq}, 2'b11);
      reg_write(3'd0, 8'h0F); @(negedge clk); check("R9", "high idle pin", {irq_oe, irq}, 2'b10);

      // R10 software trigger
      reg_write(3'd0, 8'h03);
      reg_write(3'd0, 8'h13);
      push_pulse(3, "R10");
      drain();
      reg_read(3'd1, d); check("R10", "soft status", d, 8'h40);
      reg_read(3'd0, d); check("R10", "cfg soft reads 0", d, 8'h03);
      reg_write(3'd2, 8'h40);
      reg_read(3'd1, d); check("R10", "soft cleared", d, 8'h00);
      reg_write(3'd3, 8'h3F);
      reg_write(3'd0, 8'h13);
      push(1'b1, 1'b0, 6, "R10");
      drain();
      reg_read(3'd1, d); check("R10", "disabled soft latched", d, 8'h40);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule